// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds the waiting operations for one class of execution unit in a dynamically scheduled core. When the rename stage hands it an operation, it takes a free slot and gives the operation that slot's tag. Each source operand is then settled in one of two ways. If no older operation is still going to write the source register, the value comes from the register file and is copied into the slot. If an older operation is still pending, the slot stores that producer's tag and waits.

A shared result bus carries at most one result per cycle, as a valid flag, a tag and a data word. Every waiting slot compares its pending tags with the bus and takes the data on a match. A built-in register status table keeps, for each architectural register, the tag of its latest pending writer. It drops that entry only when the bus tag equals the stored tag. Each cycle the oldest slot whose operands are all present is sent to the execution unit. The slot stays reserved until the bus carries its own tag, so a tag is never handed out twice while its result is still owed.

Because operands are copied at issue and destinations are remapped to fresh tags, reuse of a register name never holds up issue. Issue waits only when every slot is taken.

Top module: `rs_station`

## Requirements
- R1: `iss_full` is 1 exactly when every slot is occupied. An issue request made while `iss_full` is 1 is ignored: no slot is taken and the register status table is not changed.
- R2: A source register with no pending writer takes the register file value present in the issue cycle. Later changes to that register file entry do not alter the stored operand.
- R3: Issue takes the lowest-numbered free slot. `iss_tag` shows that slot's tag, which is TAG_BASE (4) plus the slot number. The destination register is remapped to this tag, so a later reader of that register waits for this writer, even when an older write to the same register is still pending.
- R4: A waiting operand whose tag equals the tag on a valid bus cycle takes the bus data. Its slot may be dispatched in the cycle after that bus cycle.
- R5: A bus cycle clears a register's pending state only if the register's stored tag equals the bus tag. A younger writer's tag is kept.
- R6: If the bus carries the awaited producer's tag in the same cycle as the issue, the operand is taken straight from the bus into the new slot.
- R7: Among slots whose operands are all ready and which have not yet been sent, the oldest by issue order is dispatched, at most one per cycle. A slot is freed by the bus cycle that carries its own tag.
- R8: A bus cycle with `cdb_valid` at 0 has no effect on any slot or on the register status table.
- R9: After reset, all slots are free, no register is pending and `disp_valid` is 0.
- R10: A dispatch presents the operation code, both operand values and the slot's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code of the issued operation |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| rf_rd1 | input | 16 | Register file value of the first source |
| rf_rd2 | input | 16 | Register file value of the second source |
| cdb_valid | input | 1 | Result bus carries a result this cycle |
| cdb_tag | input | 4 | Tag of the producer on the result bus |
| cdb_data | input | 16 | Result value on the bus |
| iss_full | output | 1 | All slots occupied; an issue is ignored |
| iss_tag | output | 4 | Tag that the next accepted issue receives |
| disp_valid | output | 1 | An operation is sent to the unit this cycle |
| disp_op | output | 4 | Operation code of the dispatched operation |
| disp_a | output | 16 | First operand value |
| disp_b | output | 16 | Second operand value |
| disp_tag | output | 4 | Tag of the dispatched slot |

## Verification
The bench uses the package values: four slots with tags 4 to 7, eight registers, 16-bit data and 4-bit tags. With only four slots, a few issues are enough to fill the station. That makes the full-stall and ignored-issue case, slot reuse after a result returns, and a three-way choice between ready slots of different ages all reachable. The eight registers leave room for two pending writers of one register, which tests that a younger tag is kept. They also allow an issue that lines up with the bus cycle it waits for.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int RS_ENTRIES  = 4;
    localparam int RS_REGS     = 8;
    localparam int RS_DW       = 16;
    localparam int RS_OPW      = 4;
    localparam int RS_TW       = 4;
    localparam int RS_TAG_BASE = 4;

    localparam int RS_RW = (RS_REGS > 1) ? $clog2(RS_REGS) : 1;
    localparam int RS_IW = (RS_ENTRIES > 1) ? $clog2(RS_ENTRIES) : 1;
    localparam int RS_AW = RS_IW;

    typedef logic [RS_DW-1:0]  data_t;
    typedef logic [RS_TW-1:0]  tag_t;
    typedef logic [RS_RW-1:0]  reg_t;
    typedef logic [RS_OPW-1:0] op_t;
    typedef logic [RS_IW-1:0]  idx_t;
    typedef logic [RS_AW-1:0]  age_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        data_t data;
    } bus_t;

    typedef struct packed {
        op_t   op;
        opnd_t a;
        opnd_t b;
    } slot_req_t;

    function automatic opnd_t resolve_src(logic busy, tag_t ptag, data_t rfv, bus_t bus);
        opnd_t o;
        if (!busy) begin
            o = '{rdy: 1'b1, tag: '0, val: rfv};
        end else if (bus.vld && bus.tag == ptag) begin
            o = '{rdy: 1'b1, tag: '0, val: bus.data};
        end else begin
            o = '{rdy: 1'b0, tag: ptag, val: '0};
        end
        return o;
    endfunction

    function automatic opnd_t snoop(opnd_t cur, bus_t bus);
        opnd_t o;
        o = cur;
        if (!cur.rdy && bus.vld && bus.tag == cur.tag) begin
            o = '{rdy: 1'b1, tag: '0, val: bus.data};
        end
        return o;
    endfunction
endpackage

// File: rtl/rs_regstat.sv
module rs_regstat
    import rs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  reg_t rd1,
    input  reg_t rd2,
    output logic busy1,
    output tag_t tag1,
    output logic busy2,
    output tag_t tag2,
    input  logic wr_en,
    input  reg_t wr_reg,
    input  tag_t wr_tag,
    input  bus_t bus
);
    logic [RS_REGS-1:0] busy_q;
    tag_t               tag_q [RS_REGS];

    assign busy1 = busy_q[rd1];
    assign tag1  = tag_q[rd1];
    assign busy2 = busy_q[rd2];
    assign tag2  = tag_q[rd2];

    for (genvar r = 0; r < RS_REGS; r++) begin : g_reg
        logic wr_here;
        logic hit;
        assign wr_here = wr_en && (wr_reg == reg_t'(r));
        assign hit     = bus.vld && busy_q[r] && (bus.tag == tag_q[r]);

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (wr_here) begin
                busy_q[r] <= 1'b1;
                tag_q[r]  <= wr_tag;
            end else if (hit) begin
                busy_q[r] <= 1'b0;
            end
        end

        // R5: a non-matching broadcast leaves the younger writer in place
        p_keep_younger_r5: assert property (@(posedge clk) disable iff (rst)
            (busy_q[r] && !wr_here && !(bus.vld && bus.tag == tag_q[r]))
            |=> (busy_q[r] && tag_q[r] == $past(tag_q[r])));

        // R5: a matching broadcast releases the register
        p_clear_match_r5: assert property (@(posedge clk) disable iff (rst)
            (busy_q[r] && !wr_here && bus.vld && bus.tag == tag_q[r]) |=> !busy_q[r]);
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter tag_t MY_TAG = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      alloc,
    input  logic      alloc_any,
    input  slot_req_t req,
    input  bus_t      bus,
    input  logic      grant,
    input  logic      free_any,
    input  age_t      free_age,
    output logic      valid,
    output logic      ready,
    output logic      free_hit,
    output age_t      age,
    output op_t       op,
    output data_t     aval,
    output data_t     bval
);
    logic  issued_q;
    opnd_t a_q, b_q;
    age_t  age_nxt;

    assign ready    = valid && !issued_q && a_q.rdy && b_q.rdy;
    assign free_hit = valid && issued_q && bus.vld && (bus.tag == MY_TAG);
    assign aval     = a_q.val;
    assign bval     = b_q.val;

    always_comb begin
        age_nxt = age;
        if (alloc_any) age_nxt = age_nxt + age_t'(1);
        if (free_any && !free_hit && (age > free_age)) age_nxt = age_nxt - age_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            issued_q <= 1'b0;
            age      <= '0;
            op       <= '0;
            a_q      <= '0;
            b_q      <= '0;
        end else if (alloc) begin
            valid    <= 1'b1;
            issued_q <= 1'b0;
            age      <= '0;
            op       <= req.op;
            a_q      <= req.a;
            b_q      <= req.b;
        end else if (valid) begin
            a_q <= snoop(a_q, bus);
            b_q <= snoop(b_q, bus);
            age <= age_nxt;
            if (grant) issued_q <= 1'b1;
            if (free_hit) valid <= 1'b0;
        end
    end

    // R4: a waiting operand captures the matching broadcast value
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !a_q.rdy && bus.vld && bus.tag == a_q.tag)
        |=> (a_q.rdy && a_q.val == $past(bus.data)));

    // R7: only a fully ready, unsent slot may be granted
    p_grant_ready_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> (valid && a_q.rdy && b_q.rdy && !issued_q));

    // R7: the broadcast of the slot's own tag releases it
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        free_hit |=> !valid);
endmodule

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RS_ENTRIES-1:0] ready,
    input  age_t                  ages [RS_ENTRIES],
    output logic [RS_ENTRIES-1:0] grant,
    output logic                  any,
    output idx_t                  sel
);
    age_t best_age;

    always_comb begin
        any      = 1'b0;
        sel      = '0;
        best_age = '0;
        for (int i = 0; i < RS_ENTRIES; i++) begin
            if (ready[i] && (!any || ages[i] > best_age)) begin
                any      = 1'b1;
                sel      = idx_t'(i);
                best_age = ages[i];
            end
        end
        grant = '0;
        if (any) grant[sel] = 1'b1;
    end

    // R7: at most one slot dispatched per cycle
    p_one_grant_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

    for (genvar i = 0; i < RS_ENTRIES; i++) begin : g_chk
        // R7: no ready slot is older than the chosen one
        p_oldest_r7: assert property (@(posedge clk) disable iff (rst)
            (any && ready[i]) |-> (ages[i] <= ages[sel]));
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [RS_OPW-1:0] iss_op,
    input  logic [RS_RW-1:0]  iss_src1,
    input  logic [RS_RW-1:0]  iss_src2,
    input  logic [RS_RW-1:0]  iss_dst,
    input  logic [RS_DW-1:0]  rf_rd1,
    input  logic [RS_DW-1:0]  rf_rd2,
    input  logic              cdb_valid,
    input  logic [RS_TW-1:0]  cdb_tag,
    input  logic [RS_DW-1:0]  cdb_data,
    output logic              iss_full,
    output logic [RS_TW-1:0]  iss_tag,
    output logic              disp_valid,
    output logic [RS_OPW-1:0] disp_op,
    output logic [RS_DW-1:0]  disp_a,
    output logic [RS_DW-1:0]  disp_b,
    output logic [RS_TW-1:0]  disp_tag
);
    bus_t      bus;
    logic      busy1, busy2;
    tag_t      ptag1, ptag2;
    slot_req_t req;
    logic      alloc_any;
    idx_t      free_idx;

    logic [RS_ENTRIES-1:0] valid_v, ready_v, free_v, alloc_v, grant_v;
    age_t  age_v [RS_ENTRIES];
    op_t   op_v  [RS_ENTRIES];
    data_t a_v   [RS_ENTRIES];
    data_t b_v   [RS_ENTRIES];
    logic  free_any;
    age_t  free_age;
    idx_t  sel;

    assign bus       = '{vld: cdb_valid, tag: cdb_tag, data: cdb_data};
    assign iss_full  = &valid_v;
    assign alloc_any = iss_valid && !iss_full;
    assign iss_tag   = tag_t'(RS_TAG_BASE) + tag_t'(free_idx);

    always_comb begin
        free_idx = '0;
        for (int i = RS_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_v[i]) free_idx = idx_t'(i);
        end
        alloc_v = '0;
        if (alloc_any) alloc_v[free_idx] = 1'b1;
    end

    always_comb begin
        free_any = |free_v;
        free_age = '0;
        for (int i = 0; i < RS_ENTRIES; i++) begin
            if (free_v[i]) free_age = age_v[i];
        end
    end

    rs_regstat u_stat (
        .clk   (clk),
        .rst   (rst),
        .rd1   (iss_src1),
        .rd2   (iss_src2),
        .busy1 (busy1),
        .tag1  (ptag1),
        .busy2 (busy2),
        .tag2  (ptag2),
        .wr_en (alloc_any),
        .wr_reg(iss_dst),
        .wr_tag(iss_tag),
        .bus   (bus)
    );

    assign req.op = iss_op;
    assign req.a  = resolve_src(busy1, ptag1, rf_rd1, bus);
    assign req.b  = resolve_src(busy2, ptag2, rf_rd2, bus);

    for (genvar i = 0; i < RS_ENTRIES; i++) begin : g_slot
        rs_slot #(.MY_TAG(tag_t'(RS_TAG_BASE + i))) u_slot (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_v[i]),
            .alloc_any(alloc_any),
            .req      (req),
            .bus      (bus),
            .grant    (grant_v[i]),
            .free_any (free_any),
            .free_age (free_age),
            .valid    (valid_v[i]),
            .ready    (ready_v[i]),
            .free_hit (free_v[i]),
            .age      (age_v[i]),
            .op       (op_v[i]),
            .aval     (a_v[i]),
            .bval     (b_v[i])
        );
    end

    rs_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .ready(ready_v),
        .ages (age_v),
        .grant(grant_v),
        .any  (disp_valid),
        .sel  (sel)
    );

    assign disp_op  = op_v[sel];
    assign disp_a   = a_v[sel];
    assign disp_b   = b_v[sel];
    assign disp_tag = tag_t'(RS_TAG_BASE) + tag_t'(sel);

    // R1: an issue against a full station takes no slot
    p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
        (iss_full && iss_valid && !free_any) |=> iss_full);

    // R9: reset leaves nothing to dispatch and a free station
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!disp_valid && !iss_full));
endmodule

// File: tb/tb_rs_station.sv
module tb_rs_station;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iss_valid = 1'b0;
    logic [RS_OPW-1:0] iss_op = '0;
    logic [RS_RW-1:0]  iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic [RS_DW-1:0]  rf_rd1, rf_rd2;
    logic              cdb_valid = 1'b0;
    logic [RS_TW-1:0]  cdb_tag = '0;
    logic [RS_DW-1:0]  cdb_data = '0;
    logic              iss_full, disp_valid;
    logic [RS_TW-1:0]  iss_tag, disp_tag;
    logic [RS_OPW-1:0] disp_op;
    logic [RS_DW-1:0]  disp_a, disp_b;

    logic [RS_DW-1:0] rf [RS_REGS];
    assign rf_rd1 = rf[iss_src1];
    assign rf_rd2 = rf[iss_src2];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [RS_OPW-1:0] op;
        logic [RS_DW-1:0]  a;
        logic [RS_DW-1:0]  b;
        logic [RS_TW-1:0]  tag;
        string             req;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    rs_station dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst),
        .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .iss_full(iss_full), .iss_tag(iss_tag),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_disp(logic [RS_OPW-1:0] op, logic [RS_DW-1:0] a,
                               logic [RS_DW-1:0] b, logic [RS_TW-1:0] tag, string req);
        exp_t e;
        e.op = op; e.a = a; e.b = b; e.tag = tag; e.req = req;
        expq.push_back(e);
    endtask

    // one cycle of stimulus; returns just after the edge that consumed it
    task automatic step(bit iv, logic [RS_OPW-1:0] op, logic [RS_RW-1:0] s1,
                        logic [RS_RW-1:0] s2, logic [RS_RW-1:0] d,
                        bit bv, logic [RS_TW-1:0] bt, logic [RS_DW-1:0] bd);
        iss_valid = iv; iss_op = op; iss_src1 = s1; iss_src2 = s2; iss_dst = d;
        cdb_valid = bv; cdb_tag = bt; cdb_data = bd;
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic issue(logic [RS_OPW-1:0] op, logic [RS_RW-1:0] s1,
                         logic [RS_RW-1:0] s2, logic [RS_RW-1:0] d);
        step(1, op, s1, s2, d, 0, 0, 0);
    endtask

    task automatic bcast(logic [RS_TW-1:0] t, logic [RS_DW-1:0] v);
        step(0, 0, 0, 0, 0, 1, t, v);
    endtask

    // monitor: compares every dispatch with the front of the scoreboard
    always @(negedge clk) begin
        if (!rst && !done && disp_valid) begin
            if (expq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7: unexpected dispatch op %0h tag %0h, expected none", disp_op, disp_tag);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.req, " op (R10)"},  32'(disp_op),  32'(e.op));
                check({e.req, " a (R10)"},   32'(disp_a),   32'(e.a));
                check({e.req, " b (R10)"},   32'(disp_b),   32'(e.b));
                check({e.req, " tag (R7)"},  32'(disp_tag), 32'(e.tag));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RS_REGS; i++) rf[i] = '0;
        rf[0] = 16'h0005; rf[1] = 16'h0011; rf[2] = 16'h0022;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        check("R9 full after reset", 32'(iss_full), 0);
        check("R9 no dispatch after reset", 32'(disp_valid), 0);
        check("R3 first tag", 32'(iss_tag), 4);

        // A: both sources from the register file
        expect_disp(4'h1, 16'h0011, 16'h0022, 4'h4, "R2 A");
        issue(4'h1, 3'd1, 3'd2, 3'd3);
        rf[1] = 16'h0099;               // later register file write, A must keep 0x11
        idle(1);
        check("R3 slot held until result", 32'(iss_tag), 5);

        issue(4'h2, 3'd3, 3'd1, 3'd5);  // B waits on tag 4
        issue(4'h3, 3'd3, 3'd3, 3'd3);  // C waits on tag 4, remaps r3 to 6
        check("R3 lowest free slot", 32'(iss_tag), 7);
        issue(4'h4, 3'd3, 3'd2, 3'd7);  // D waits on tag 6 (younger writer)
        check("R1 full when all slots taken", 32'(iss_full), 1);
        issue(4'h9, 3'd1, 3'd2, 3'd1);  // ignored
        check("R1 full stays after ignored issue", 32'(iss_full), 1);
        step(0, 0, 0, 0, 0, 0, 4'h4, 16'hDEAD);
        check("R8 invalid bus wakes nothing", 32'(disp_valid), 0);

        rf[3] = 16'h0BAD;               // r3 must not be read: younger writer pending
        expect_disp(4'h2, 16'h0444, 16'h0099, 4'h5, "R4 B");
        expect_disp(4'h3, 16'h0444, 16'h0444, 4'h6, "R7 C");
        bcast(4'h4, 16'h0444);
        check("R1 slot freed by own tag", 32'(iss_full), 0);
        check("R3 freed slot reused first", 32'(iss_tag), 4);
        idle(2);

        issue(4'h5, 3'd3, 3'd1, 3'd2);  // F waits on tag 6 (R5)
        check("R1 full again", 32'(iss_full), 1);
        rf[5] = 16'h0555;
        bcast(4'h5, 16'h0555);
        check("R7 slot of B freed", 32'(iss_tag), 5);

        expect_disp(4'h4, 16'h0666, 16'h0022, 4'h7, "R7 D oldest");
        expect_disp(4'h5, 16'h0666, 16'h0099, 4'h4, "R5 F");
        expect_disp(4'h6, 16'h0666, 16'h0555, 4'h5, "R6 G");
        step(1, 4'h6, 3'd3, 3'd5, 3'd0, 1, 4'h6, 16'h0666);  // G issues as tag 6 broadcasts
        rf[3] = 16'h0666;
        idle(3);
        check("R7 all expected dispatched", 32'(expq.size()), 0);

        bcast(4'h7, 16'h0777);
        bcast(4'h4, 16'h0444);
        bcast(4'h5, 16'h0055);
        check("R7 all slots free", 32'(iss_full), 0);
        check("R3 tag after drain", 32'(iss_tag), 4);

        // r1 must not be pending: the ignored issue wrote no status
        expect_disp(4'h7, 16'h0099, 16'h0099, 4'h4, "R1 H");
        issue(4'h7, 3'd1, 3'd1, 3'd4);
        idle(2);
        bcast(4'h4, 16'h0001);
        idle(1);
        check("R1 nothing left to dispatch", 32'(expq.size()), 0);
        check("R8 idle after drain", 32'(disp_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule